// File: doc/BRIEF.md
# 8-to-16-bit Peripheral Bus I/O Bridge

This block lets a CPU with an 8-bit data bus run I/O cycles on a 16-bit peripheral bus on which cards are addressed by selection. Each qualified CPU I/O cycle is decoded into exactly one of eight bus strobes. The strobe is picked by two address bits and by the direction of the cycle. The strobe is registered and is held steady for the whole cycle. When the request and the read/write strobe are released together, no other output can pulse.

A 16-bit transfer takes two CPU I/O instructions. For a write, the CPU first loads the upper byte into an outbound byte latch. It then issues the data write, which drives its own byte as the low half and the latch as the high half. For a read, the data-read cycle returns the low half to the CPU and captures the high half in an inbound byte latch. A later latch-read cycle returns that byte to the CPU. The low six address bits go straight to the bus.

There is no valid/ready handshake at the edges. The CPU cycle itself paces every transfer, so there is no back-pressure path. The CPU inputs are taken to be synchronous to `clk`.

Top module: `pbus_io_bridge`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `bus_strobe` is 0, both byte latches are 0 (so `bus_wdata_hi` is 0), and `cpu_rdata` and `cpu_rdata_oe` are 0.
- R2: A cycle qualifies when `io_req_n`=0, `m1_n`=1 and exactly one of `rd_n`/`wr_n` is 0. At the first rising edge with a qualified cycle and no strobe active, the strobe with bit index {cpu_addr[7], cpu_addr[6], write} goes high. Write is 1 when `wr_n`=0. The resulting codes are: bit0 status read, bit1 card select, bit2 data read, bit3 interrupt mask, bit4 upper-byte latch read, bit5 data write, bit6 serial-bus access read, bit7 upper-byte latch load.
- R3: While `m1_n`=0 (interrupt acknowledge), no strobe starts, even with `io_req_n`=0.
- R4: No strobe starts while `io_req_n`=1, or while `rd_n` and `wr_n` are both 0 or both 1.
- R5: At most one strobe bit is high at any time. Once set, the strobe stays unchanged while the cycle stays qualified, even if the address bits or the direction change. It clears at the first rising edge after `io_req_n`, `m1_n` or both read/write strobes end the cycle.
- R6: During a data read (bit2), `cpu_rdata` equals `bus_rdata_lo`. The inbound latch loads `bus_rdata_hi` at every rising edge at which bit2 is high.
- R7: During an upper-byte latch read (bit4), `cpu_rdata` equals the inbound latch. That latch keeps its value through every cycle other than a data read.
- R8: The outbound latch loads `cpu_wdata` at every rising edge at which bit7 is high. `bus_wdata_hi` always shows it, and it keeps its value through every other cycle.
- R9: `bus_wdata_lo` always equals `cpu_wdata`, so a data write (bit5) puts the CPU byte on the low half and the outbound latch on the high half.
- R10: `bus_addr` always equals `cpu_addr[5:0]`.
- R11: `cpu_rdata_oe` is high exactly while a read strobe (bit0, 2, 4 or 6) is high. For the status and serial-bus reads `cpu_rdata` equals `bus_rdata_lo`. With no read strobe high, `cpu_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_req_n | input | 1 | CPU I/O request, active low |
| m1_n | input | 1 | CPU opcode-fetch / acknowledge marker, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| cpu_addr | input | 8 | CPU I/O address, low byte |
| cpu_wdata | input | 8 | Data driven by the CPU |
| cpu_rdata | output | 8 | Data returned to the CPU |
| cpu_rdata_oe | output | 1 | CPU data bus drive enable |
| bus_addr | output | 6 | Peripheral bus address |
| bus_wdata_lo | output | 8 | Low half of bus write data |
| bus_wdata_hi | output | 8 | High half of bus write data (outbound latch) |
| bus_rdata_lo | input | 8 | Low half of bus read data |
| bus_rdata_hi | input | 8 | High half of bus read data |
| bus_strobe | output | 8 | One-hot peripheral strobes |

## Verification
The hardest case to reach from the ports is the end of a cycle. There the address and direction may move while the request is still low, and then every control line is released on the same edge. The directed stimulus holds `io_req_n` low, flips the address bits and swaps read for write in mid-cycle, and checks that the strobe has not moved. It then releases the request and both strobes in one step and checks that the strobe falls to zero with no other bit rising. Both latches are checked for retention by running the unrelated cycles between each load and its later use.

// File: rtl/pbus_io_pkg.sv
package pbus_io_pkg;
  localparam int unsigned STB_N   = 8;
  localparam int unsigned STB_IW  = $clog2(STB_N);

  localparam int unsigned STB_STATUS  = 0;
  localparam int unsigned STB_SELECT  = 1;
  localparam int unsigned STB_DRD     = 2;
  localparam int unsigned STB_MASK    = 3;
  localparam int unsigned STB_HRD     = 4;
  localparam int unsigned STB_DWR     = 5;
  localparam int unsigned STB_SER     = 6;
  localparam int unsigned STB_HLD     = 7;

  typedef logic [STB_N-1:0] strobe_t;

  typedef struct packed {
    logic req;
    logic ack;
    logic rd;
    logic wr;
  } cyc_ctl_t;

  function automatic strobe_t to_onehot(input logic [STB_IW-1:0] idx);
    strobe_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction

  function automatic strobe_t read_mask();
    strobe_t m;
    m = '0;
    for (int i = 0; i < STB_N; i += 2) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
  import pbus_io_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cyc_ctl_t         ctl,
  input  logic [SEL_W-1:0] sel,
  output strobe_t          strobe
);
  localparam int unsigned IDX_W = SEL_W + 1;

  logic            qual;
  logic            ends;
  logic            busy;
  logic [IDX_W-1:0] idx;
  strobe_t         strobe_q;
  strobe_t         strobe_d;

  assign qual = ctl.req && !ctl.ack && (ctl.rd ^ ctl.wr);
  assign ends = !ctl.req || ctl.ack || !(ctl.rd || ctl.wr);
  assign busy = |strobe_q;
  assign idx  = {sel, ctl.wr};

  always_comb begin
    strobe_d = strobe_q;
    if (!busy) begin
      if (qual) strobe_d = to_onehot(STB_IW'(idx));
    end else if (ends) begin
      strobe_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= '0;
    else        strobe_q <= strobe_d;
  end

  assign strobe = strobe_q;
endmodule

// File: rtl/pbus_byte_latch.sv
module pbus_byte_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pbus_rdata_mux.sv
module pbus_rdata_mux
  import pbus_io_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  strobe_t      strobe,
  input  logic [W-1:0] bus_lo,
  input  logic [W-1:0] hi_latch,
  output logic [W-1:0] rdata,
  output logic         oe
);
  localparam strobe_t RD_MASK = read_mask();

  always_comb begin
    oe = |(strobe & RD_MASK);
    if (strobe[STB_HRD]) rdata = hi_latch;
    else if (oe)         rdata = bus_lo;
    else                 rdata = '0;
  end
endmodule

// File: rtl/pbus_io_bridge.sv
module pbus_io_bridge
  import pbus_io_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 8,
  parameter int unsigned BUS_AW = 6,
  parameter int unsigned SEL_LO = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_req_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              cpu_rdata_oe,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata_lo,
  output logic [DW-1:0]     bus_wdata_hi,
  input  logic [DW-1:0]     bus_rdata_lo,
  input  logic [DW-1:0]     bus_rdata_hi,
  output logic [7:0]        bus_strobe
);
  localparam int unsigned SEL_W = STB_IW - 1;

  cyc_ctl_t          ctl;
  strobe_t           stb;
  logic [DW-1:0]     hl_q;
  logic [DW-1:0]     lh_q;

  assign ctl.req = !io_req_n;
  assign ctl.ack = !m1_n;
  assign ctl.rd  = !rd_n;
  assign ctl.wr  = !wr_n;

  pbus_strobe_gen #(.SEL_W(SEL_W)) u_stb (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .sel    (cpu_addr[SEL_LO +: SEL_W]),
    .strobe (stb)
  );

  pbus_byte_latch #(.W(DW)) u_hl (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (stb[STB_DRD]),
    .d     (bus_rdata_hi),
    .q     (hl_q)
  );

  pbus_byte_latch #(.W(DW)) u_lh (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (stb[STB_HLD]),
    .d     (cpu_wdata),
    .q     (lh_q)
  );

  pbus_rdata_mux #(.W(DW)) u_rmux (
    .strobe   (stb),
    .bus_lo   (bus_rdata_lo),
    .hi_latch (hl_q),
    .rdata    (cpu_rdata),
    .oe       (cpu_rdata_oe)
  );

  assign bus_addr     = cpu_addr[BUS_AW-1:0];
  assign bus_wdata_lo = cpu_wdata;
  assign bus_wdata_hi = lh_q;
  assign bus_strobe   = stb;
endmodule

// File: rtl/pbus_io_bridge_chk.sv
module pbus_io_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       io_req_n,
  input logic       m1_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [7:0] bus_strobe,
  input logic [7:0] bus_wdata_hi,
  input logic       cpu_rdata_oe
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_strobe));

  p_ack_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe == 8'h00 && !m1_n) |=> bus_strobe == 8'h00);

  p_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe == 8'h00 && (io_req_n || (rd_n == wr_n))) |=> bus_strobe == 8'h00);

  p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe == 8'h00 && !io_req_n && m1_n && !rd_n && wr_n)
      |=> ($countones(bus_strobe) == 1 && (bus_strobe & 8'h55) != 8'h00));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe != 8'h00 && !io_req_n && m1_n && !(rd_n && wr_n)) |=> $stable(bus_strobe));

  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe != 8'h00 && io_req_n) |=> bus_strobe == 8'h00);

  p_lh_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_strobe[7] |=> $stable(bus_wdata_hi));

  p_oe_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe == 8'h00) |-> !cpu_rdata_oe);
endmodule

bind pbus_io_bridge pbus_io_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .io_req_n     (io_req_n),
  .m1_n         (m1_n),
  .rd_n         (rd_n),
  .wr_n         (wr_n),
  .bus_strobe   (bus_strobe),
  .bus_wdata_hi (bus_wdata_hi),
  .cpu_rdata_oe (cpu_rdata_oe)
);

// File: tb/sim_pbus_io_bridge.sv
module sim_pbus_io_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       io_req_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, bus_rdata_lo = '0, bus_rdata_hi = '0;
  logic [7:0] cpu_rdata, bus_wdata_lo, bus_wdata_hi, bus_strobe;
  logic [5:0] bus_addr;
  logic       cpu_rdata_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_lh = 8'h00;

  always #2.5 clk = ~clk;

  pbus_io_bridge u0 (
    .clk(clk), .rst_n(rst_n), .io_req_n(io_req_n), .m1_n(m1_n), .rd_n(rd_n), .wr_n(wr_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .bus_addr(bus_addr), .bus_wdata_lo(bus_wdata_lo), .bus_wdata_hi(bus_wdata_hi),
    .bus_rdata_lo(bus_rdata_lo), .bus_rdata_hi(bus_rdata_hi), .bus_strobe(bus_strobe)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {sel[1:0], wr, wdata, rd_hi, rd_lo, exp_strobe, exp_rdata}
  localparam int NV = 10;
  localparam logic [42:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h00, 8'h00, 8'h11, 8'h01, 8'h11},
    {2'd0, 1'b1, 8'h22, 8'h00, 8'h00, 8'h02, 8'h00},
    {2'd1, 1'b0, 8'h00, 8'hA5, 8'h3C, 8'h04, 8'h3C},
    {2'd1, 1'b1, 8'h33, 8'h00, 8'h00, 8'h08, 8'h00},
    {2'd3, 1'b1, 8'h5A, 8'h00, 8'h00, 8'h80, 8'h00},
    {2'd2, 1'b1, 8'h77, 8'h00, 8'h00, 8'h20, 8'h00},
    {2'd2, 1'b0, 8'h00, 8'h00, 8'h99, 8'h10, 8'hA5},
    {2'd3, 1'b0, 8'h00, 8'h00, 8'h42, 8'h40, 8'h42},
    {2'd1, 1'b0, 8'h00, 8'hC3, 8'h0F, 8'h04, 8'h0F},
    {2'd2, 1'b0, 8'h00, 8'h00, 8'h66, 8'h10, 8'hC3}
  };

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 strobe in reset", bus_strobe, 8'h00);
    chk("R1 hi latch in reset", bus_wdata_hi, 8'h00);
    chk("R1 rdata in reset", cpu_rdata, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobe after reset", bus_strobe, 8'h00);
    chk("R11 oe idle", {7'b0, cpu_rdata_oe}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      v = VEC[i];
      cpu_addr     = {v[42:41], 6'(i + 40)};
      wr_n         = !v[40];
      rd_n         = v[40];
      cpu_wdata    = v[39:32];
      bus_rdata_hi = v[31:24];
      bus_rdata_lo = v[23:16];
      io_req_n     = 1'b0;
      @(negedge clk);
      chk("R2 strobe code", bus_strobe, v[15:8]);
      chk("R6 R7 R11 cpu rdata", cpu_rdata, v[7:0]);
      chk("R11 oe", {7'b0, cpu_rdata_oe}, {7'b0, ~v[40]});
      chk("R10 addr pass", {2'b0, bus_addr}, {2'b0, 6'(i + 40)});
      chk("R9 low write byte", bus_wdata_lo, v[39:32]);
      chk("R8 R9 high write byte", bus_wdata_hi, model_lh);
      @(negedge clk);
      io_req_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
      @(negedge clk);
      if (v[15:8] == 8'h80) model_lh = v[39:32];
      chk("R5 cleared after cycle", bus_strobe, 8'h00);
      chk("R8 outbound latch", bus_wdata_hi, model_lh);
    end

    // R3: acknowledge cycle
    m1_n = 1'b0; io_req_n = 1'b0; rd_n = 1'b0; cpu_addr = 8'h40;
    repeat (2) @(negedge clk);
    chk("R3 no strobe on acknowledge", bus_strobe, 8'h00);
    io_req_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
    @(negedge clk);

    // R4: both direction strobes, and direction without request
    io_req_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R4 rd and wr together", bus_strobe, 8'h00);
    io_req_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 no request", bus_strobe, 8'h00);
    rd_n = 1'b1;
    @(negedge clk);

    // R5: mid-cycle changes hold the strobe, then a joint release
    cpu_addr = 8'h00; wr_n = 1'b0; cpu_wdata = 8'hE1; io_req_n = 1'b0;
    @(negedge clk);
    chk("R5 select started", bus_strobe, 8'h02);
    cpu_addr = 8'hC0; wr_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R5 held after change", bus_strobe, 8'h02);
    chk("R8 untouched by other write", bus_wdata_hi, model_lh);
    io_req_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R5 joint release", bus_strobe, 8'h00);

    // R7: inbound latch still holds after unrelated cycles
    cpu_addr = 8'h80; rd_n = 1'b0; io_req_n = 1'b0; bus_rdata_lo = 8'h13;
    @(negedge clk);
    chk("R7 inbound latch retained", cpu_rdata, 8'hC3);
    io_req_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    chk("R11 rdata zero when idle", cpu_rdata, 8'h00);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule